// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a small set of asynchronous interrupt pins and turns qualifying events on them into sticky flags and gated interrupt requests. Each pin has its own two-bit sense field that picks the trigger: low level, any change, falling edge or rising edge. A flag stays set until the CPU acknowledges the matching vector or software writes a one to that flag bit. A request line for a pin is raised when three things are all set: the pin's enable, the global interrupt enable, and the pin's flag. In low-level mode the request is also raised for as long as the pin stays low.

A second source covers a whole input port. When its enable and the global enable are both set, any port pin sampled low raises a single port request. All pin and port inputs first pass through a synchronizer. Every output is registered.

Configuration is held inside the block: a single write strobe loads the sense fields, the per-pin enables and the port enable. A separate strobe carries a write-one-to-clear mask for the flags.

Top module: `ext_irq_sense`

## Requirements
- R1: The sense field of pin i is cfg_sense_i[2i+1:2i]. It is encoded as 00 = low level, 01 = any change, 10 = falling edge, 11 = rising edge. An event that does not match the selected mode leaves the flag at 0.
- R2: A pin change driven between clock edges is visible in flag_o on the third rising edge after it, and not on the second. The path is two synchronizer flops and then the flag register.
- R3: irq_o[i] is 1 only while pin_en[i] and gie_i are both set and flag_o[i] is set (low-level mode also applies, see R7). irq_o[i] changes on the same edge as the flag. With gie_i low, a set flag raises no request.
- R4: A one on ack_i[i] clears flag_o[i] on the next edge.
- R5: When flag_we_i is high, each one bit in flag_wdata_i clears the matching flag on the next edge. Zero bits leave their flags unchanged.
- R6: When port_en and gie_i are set, port_irq_o goes high on the third edge after any bit of port_i goes low. It falls again on the third edge after all bits are high or after either enable drops.
- R7: In low-level mode, irq_o[i] stays high while the synchronized pin is low, even after the flag has been cleared. The flag itself is set on the edge where the pin's low level begins.
- R8: Reset (rst high, synchronous) clears all flags, requests, pin enables, the port enable and the sense fields.
- R9: If a qualifying event and a clear (acknowledge or write-one) meet on the same edge, the flag ends up set.
- R10: cfg_we_i loads cfg_sense_i, cfg_pin_en_i and cfg_port_en_i. When cfg_we_i is low, changes on those inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Asynchronous interrupt pins |
| port_i | input | PORT_W | Asynchronous port pins for the any-low source |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | NUM_PINS | Vector acknowledge strobe per pin |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sense_i | input | 2*NUM_PINS | Sense fields, two bits per pin |
| cfg_pin_en_i | input | NUM_PINS | Per-pin interrupt enables |
| cfg_port_en_i | input | 1 | Port any-low enable |
| flag_we_i | input | 1 | Flag clear write strobe |
| flag_wdata_i | input | NUM_PINS | Write-one-to-clear mask |
| flag_o | output | NUM_PINS | Sticky event flags |
| irq_o | output | NUM_PINS | Per-pin interrupt requests |
| port_irq_o | output | 1 | Port any-low interrupt request |

## Verification
The hardest case to reach is a pin event and a flag clear landing on the same clock edge. The event only becomes visible two synchronizer edges after the pin moves. The bench therefore changes the pin, counts exactly two rising edges, and then asserts the clear strobe for the third edge. It does this once with the flag already set from an earlier event, so the event must win for the flag to stay high. The low-level hold is a similar case: the request has to stay up after the flag is cleared, so the bench clears the flag while the pin is still held low.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= {WIDTH{RST_VAL}};
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_pin_det.sv
module ext_irq_pin_det
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       s_i,
  input  logic [1:0] sense_i,
  input  logic       en_i,
  input  logic       gie_i,
  input  logic       ack_i,
  input  logic       clr_i,
  output logic       flag_o,
  output logic       irq_o
);
  logic prev_q, flag_q, irq_q;
  logic evt, flag_d, low_hold;

  always_comb begin
    unique case (sense_e'(sense_i))
      SENSE_LOW:  evt = ~s_i & prev_q;
      SENSE_ANY:  evt = s_i ^ prev_q;
      SENSE_FALL: evt = ~s_i & prev_q;
      default:    evt = s_i & ~prev_q;
    endcase
    low_hold = (sense_e'(sense_i) == SENSE_LOW) & ~s_i;
    if (evt)                flag_d = 1'b1;
    else if (ack_i | clr_i) flag_d = 1'b0;
    else                    flag_d = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= s_i;
      flag_q <= flag_d;
      irq_q  <= en_i & gie_i & (flag_d | low_hold);
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> ($past(s_i) != $past(prev_q))); // R2
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(en_i & gie_i)); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack_i && s_i == prev_q) |=> !flag_q); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_i && s_i == prev_q) |=> !flag_q); // R5
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !ack_i && !clr_i) |=> flag_q); // R5
  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en_i && gie_i && sense_i == 2'b00 && !s_i) |=> irq_q); // R7
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    ((s_i ^ prev_q) && sense_i == 2'b01) |=> flag_q); // R9
endmodule

// File: rtl/ext_irq_port_low.sv
module ext_irq_port_low #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] port_s_i,
  input  logic              en_i,
  input  logic              gie_i,
  output logic              irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= en_i & gie_i & ~(&port_s_i);
  end

  assign irq_o = irq_q;

  AST_PORT_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(en_i && gie_i)); // R6
  AST_PORT_LOW_FIRES: assert property (@(posedge clk) disable iff (rst)
    (en_i && gie_i && !(&port_s_i)) |=> irq_q); // R6
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS    = 2,
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic [PORT_W-1:0]     port_i,
  input  logic                  gie_i,
  input  logic [NUM_PINS-1:0]   ack_i,
  input  logic                  cfg_we_i,
  input  logic [2*NUM_PINS-1:0] cfg_sense_i,
  input  logic [NUM_PINS-1:0]   cfg_pin_en_i,
  input  logic                  cfg_port_en_i,
  input  logic                  flag_we_i,
  input  logic [NUM_PINS-1:0]   flag_wdata_i,
  output logic [NUM_PINS-1:0]   flag_o,
  output logic [NUM_PINS-1:0]   irq_o,
  output logic                  port_irq_o
);
  localparam int SENSE_W = 2 * NUM_PINS;

  logic [SENSE_W-1:0]  sense_q;
  logic [NUM_PINS-1:0] pin_en_q;
  logic                port_en_q;
  logic [NUM_PINS-1:0] pin_s;
  logic [PORT_W-1:0]   port_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q   <= '0;
      pin_en_q  <= '0;
      port_en_q <= 1'b0;
    end else if (cfg_we_i) begin
      sense_q   <= cfg_sense_i;
      pin_en_q  <= cfg_pin_en_i;
      port_en_q <= cfg_port_en_i;
    end
  end

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (rst)
    !cfg_we_i |=> $stable(pin_en_q) && $stable(sense_q)); // R10

  ext_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(pin_s)
  );

  ext_irq_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_port_sync (
    .clk(clk), .rst(rst), .d_i(port_i), .q_o(port_s)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    ext_irq_pin_det u_det (
      .clk    (clk),
      .rst    (rst),
      .s_i    (pin_s[i]),
      .sense_i(sense_q[2*i +: 2]),
      .en_i   (pin_en_q[i]),
      .gie_i  (gie_i),
      .ack_i  (ack_i[i]),
      .clr_i  (flag_we_i & flag_wdata_i[i]),
      .flag_o (flag_o[i]),
      .irq_o  (irq_o[i])
    );
  end

  ext_irq_port_low #(.PORT_W(PORT_W)) u_port_low (
    .clk(clk), .rst(rst), .port_s_i(port_s), .en_i(port_en_q),
    .gie_i(gie_i), .irq_o(port_irq_o)
  );
endmodule

// File: tb/ext_irq_sense_tb.sv
`timescale 1ns/1ps
module ext_irq_sense_tb;
  localparam int NP = 2;
  localparam int PW = 8;

  logic clk = 0;
  logic rst;
  logic [NP-1:0]   pin;
  logic [PW-1:0]   port;
  logic            gie;
  logic [NP-1:0]   ack;
  logic            cfg_we;
  logic [2*NP-1:0] cfg_sense;
  logic [NP-1:0]   cfg_pin_en;
  logic            cfg_port_en;
  logic            flag_we;
  logic [NP-1:0]   flag_wdata;
  logic [NP-1:0]   flag;
  logic [NP-1:0]   irq;
  logic            port_irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ext_irq_sense #(.NUM_PINS(NP), .PORT_W(PW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .pin_i(pin), .port_i(port), .gie_i(gie), .ack_i(ack),
    .cfg_we_i(cfg_we), .cfg_sense_i(cfg_sense), .cfg_pin_en_i(cfg_pin_en),
    .cfg_port_en_i(cfg_port_en), .flag_we_i(flag_we), .flag_wdata_i(flag_wdata),
    .flag_o(flag), .irq_o(irq), .port_irq_o(port_irq)
  );

  // {sense[1:0], from, to, expected flag}
  localparam logic [4:0] VEC [8] = '{
    {2'b11, 1'b0, 1'b1, 1'b1}, {2'b11, 1'b1, 1'b0, 1'b0},
    {2'b10, 1'b1, 1'b0, 1'b1}, {2'b10, 1'b0, 1'b1, 1'b0},
    {2'b01, 1'b0, 1'b1, 1'b1}, {2'b01, 1'b1, 1'b0, 1'b1},
    {2'b00, 1'b1, 1'b0, 1'b1}, {2'b00, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(input logic [2*NP-1:0] s, input logic [NP-1:0] en, input logic pe);
    cfg_sense = s; cfg_pin_en = en; cfg_port_en = pe; cfg_we = 1;
    edges(1);
    cfg_we = 0;
  endtask

  task automatic clear_all();
    flag_we = 1; flag_wdata = '1;
    edges(1);
    flag_we = 0; flag_wdata = '0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    rst = 1; pin = '1; port = '1; gie = 0; ack = '0; cfg_we = 0;
    cfg_sense = '0; cfg_pin_en = '0; cfg_port_en = 0; flag_we = 0; flag_wdata = '0;
    edges(4);
    rst = 0;
    edges(1);
    // R8 reset state
    check(flag == '0 && irq == '0 && port_irq == 0, "R8", {flag, irq}, 0);

    // R10: config inputs change without strobe -> no request even with flag set
    cfg_sense = 4'b0101; cfg_pin_en = '1; gie = 1;
    pin[0] = 0;
    edges(3);
    check(flag[0] == 1 && irq[0] == 0, "R10", irq[0], 0);
    pin[0] = 1;
    edges(3);
    clear_all();

    // R1/R2 vector walk on pin 0, enables off
    for (int v = 0; v < 8; v++) begin
      cfg({2'b00, VEC[v][4:3]}, '0, 0);
      pin[0] = VEC[v][2];
      edges(4);
      clear_all();
      pin[0] = VEC[v][1];
      edges(2);
      if (VEC[v][0]) check(flag[0] == 0, "R2", flag[0], 0);
      edges(1);
      check(flag[0] == VEC[v][0], "R1", flag[0], VEC[v][0]);
      edges(2);
      clear_all();
    end
    pin = '1;
    edges(4);
    clear_all();

    // R3: gating with enable and global enable, pin 1 rising... use falling
    cfg(4'b1000, 2'b10, 0);
    gie = 0;
    pin[1] = 0;
    edges(3);
    check(flag[1] == 1 && irq[1] == 0, "R3", irq[1], 0);
    gie = 1;
    edges(1);
    check(irq[1] == 1, "R3", irq[1], 1);
    check(irq[0] == 0, "R3", irq[0], 0);
    // R4 acknowledge
    ack[1] = 1;
    edges(1);
    ack[1] = 0;
    check(flag[1] == 0 && irq[1] == 0, "R4", flag[1], 0);
    pin[1] = 1;
    edges(3);

    // R5: write zero keeps, write one clears
    cfg(4'b0101, 2'b11, 0);
    pin = 2'b00;
    edges(3);
    check(flag == 2'b11, "R5", flag, 3);
    flag_we = 1; flag_wdata = 2'b10;
    edges(1);
    flag_we = 0; flag_wdata = '0;
    check(flag == 2'b01, "R5", flag, 1);

    // R9: event and clear on the same edge, flag already set
    pin[0] = 1;
    edges(2);
    flag_we = 1; flag_wdata = 2'b01;
    edges(1);
    flag_we = 0; flag_wdata = '0;
    check(flag[0] == 1, "R9", flag[0], 1);
    clear_all();
    check(flag[0] == 0, "R9", flag[0], 0);
    pin = '1;
    edges(3);
    clear_all();

    // R7: low-level hold after flag clear
    cfg(4'b0000, 2'b01, 0);
    pin[0] = 0;
    edges(3);
    check(flag[0] == 1 && irq[0] == 1, "R7", irq[0], 1);
    clear_all();
    check(flag[0] == 0 && irq[0] == 1, "R7", irq[0], 1);
    pin[0] = 1;
    edges(3);
    check(irq[0] == 0, "R7", irq[0], 0);

    // R6: port any-low
    cfg(4'b0000, 2'b00, 1);
    port[5] = 0;
    edges(2);
    check(port_irq == 0, "R6", port_irq, 0);
    edges(1);
    check(port_irq == 1, "R6", port_irq, 1);
    port = '1;
    edges(3);
    check(port_irq == 0, "R6", port_irq, 0);
    port[0] = 0;
    gie = 0;
    edges(3);
    check(port_irq == 0, "R6", port_irq, 0);

    // R8: reset mid-activity clears state
    gie = 1;
    edges(3);
    rst = 1;
    edges(2);
    rst = 0;
    edges(3);
    check(port_irq == 0 && flag == '0, "R8", port_irq, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule